// File: doc/BRIEF.md
# Interrupt Routing Matrix

This block gathers 32 level-sensitive interrupt request lines from the chip's subsystems and steers them onto six processor interrupt inputs. Each processor input has its own 32-bit route register. A set bit in that register connects the matching source line to that input. Any source may be connected to any number of inputs, including none.

A six-bit enable mask gates each processor input as a whole. A read-only status word shows the present level of all 32 source lines. The block has no hardware priority. Software reads the status word and decides the order of service itself.

Outputs are registered once. An output follows its sources with one cycle of delay, both when it asserts and when it drops. A simple write/read port configures the block. Reads are registered and return data one cycle after the address is presented.

Top module: `irq_route_matrix`

## Requirements
- R1: After a synchronous active-low reset, all six outputs are low, all route registers read zero and the enable mask reads zero.
- R2: A write to address k (k = 0..5) stores the full 32-bit write data as route register k. A read of address k returns that value one cycle after the address is presented.
- R3: Address 6 holds the enable mask in write-data bits [5:0], where bit k = 1 lets output k through. Bits [31:6] always read as zero.
- R4: A read of address 7 returns the level of the 32 source lines sampled at the read. Writes to address 7 have no effect.
- R5: Output k goes high on the cycle after some source bit is high, its bit is set in route register k and mask bit k is 1.
- R6: While mask bit k is 0, output k stays low, whatever sources are routed to it and active.
- R7: An output stays high for as long as a routed, enabled source stays high. It drops one cycle after the last such source drops.
- R8: A source whose bit is set in several route registers drives all of those outputs in the same cycle.
- R9: Addresses 8..15 read as zero. Writes to them change no route register and do not change the mask.
- R10: An active source whose bit is clear in route register k does not assert output k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | 32 | Level-sensitive source request lines |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| cpu_irq | output | 6 | Processor interrupt inputs |

## Verification
A corrupted route bit shows up one cycle after the matching source rises. That output either fails to assert or asserts when no routed source is present. A wrong mask bit or a stuck output flop shows up in the same cycle window, and it can also be seen as an output that stays high one cycle after all sources drop. Configuration storage faults appear at the next readback of the affected address. Decode faults appear as a change to a route or mask value after a write to another address.

// File: rtl/irq_route_pkg.sv
// Package: shared types and address decode for the interrupt routing matrix.
// Assumes route registers occupy addresses 0..NUM_OUT-1, followed by the
// mask, then the status word; everything above is unmapped.
package irq_route_pkg;

    typedef enum logic [1:0] {
        KIND_ROUTE = 2'd0,
        KIND_MASK  = 2'd1,
        KIND_STAT  = 2'd2,
        KIND_NONE  = 2'd3
    } reg_kind_e;

    // Classify a register address for a matrix with n outputs.
    function automatic reg_kind_e decode_addr(input int unsigned a, input int unsigned n);
        if (a < n)
            return KIND_ROUTE;
        else if (a == n)
            return KIND_MASK;
        else if (a == n + 1)
            return KIND_STAT;
        else
            return KIND_NONE;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
// Module: configuration storage for the routing matrix. Holds one route
// word per output and the output enable mask, and returns registered read
// data. Assumes writes are single-cycle strobes and reads have one cycle
// of latency. The status word is the raw source level at the read edge.
module irq_cfg_regs
    import irq_route_pkg::*;
#(
    parameter int SRC_W   = 32,
    parameter int NUM_OUT = 6,
    parameter int ADDR_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [SRC_W-1:0]                wdata,
    input  logic [SRC_W-1:0]                src,
    output logic [SRC_W-1:0]                rdata,
    output logic [NUM_OUT-1:0][SRC_W-1:0]   route,
    output logic [NUM_OUT-1:0]              enable
);
    localparam int IDX_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
    localparam int PAD_W = SRC_W - NUM_OUT;

    reg_kind_e kind;
    logic [IDX_W-1:0] idx;

    // Classify the current address once for writes and reads.
    always_comb begin
        kind = decode_addr(32'(addr), NUM_OUT);
        idx  = addr[IDX_W-1:0];
    end

    genvar g;
    generate
        for (g = 0; g < NUM_OUT; g++) begin : g_route
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
            // Store the route word for output g when its address is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    route[g] <= '0;
                else if (we && addr == MY_ADDR)
                    route[g] <= wdata;
            end
        end
    endgenerate

    // Store the enable mask from the low write-data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= '0;
        else if (we && kind == KIND_MASK)
            enable <= wdata[NUM_OUT-1:0];
    end

    // Register read data selected by the address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else begin
            case (kind)
                KIND_ROUTE: rdata <= route[idx];
                KIND_MASK:  rdata <= {{PAD_W{1'b0}}, enable};
                KIND_STAT:  rdata <= src;
                default:    rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_route_lane.sv
// Module: one output lane of the matrix. Reduces the sources selected by
// its route word to one request, gates that request by the lane enable and
// registers the result. Assumes sources are level-sensitive, so no edge
// capture is kept.
module irq_route_lane #(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    input  logic [SRC_W-1:0] route,
    input  logic             enable,
    output logic             irq
);
    logic hit;

    // Any routed source that is currently high.
    always_comb hit = |(src & route);

    // Register the gated request for the processor input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= hit & enable;
    end

endmodule

// File: rtl/irq_route_matrix.sv
// Module: top of the interrupt routing matrix. Connects the configuration
// registers to one lane per processor interrupt input. Assumes software
// handles priority; the block only routes, gates and registers levels.
module irq_route_matrix #(
    parameter int SRC_W   = 32,
    parameter int NUM_OUT = 6,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   src_irq,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [SRC_W-1:0]   cfg_wdata,
    output logic [SRC_W-1:0]   cfg_rdata,
    output logic [NUM_OUT-1:0] cpu_irq
);
    logic [NUM_OUT-1:0][SRC_W-1:0] route_q;
    logic [NUM_OUT-1:0]            mask_q;

    irq_cfg_regs #(
        .SRC_W  (SRC_W),
        .NUM_OUT(NUM_OUT),
        .ADDR_W (ADDR_W)
    ) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .src   (src_irq),
        .rdata (cfg_rdata),
        .route (route_q),
        .enable(mask_q)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_OUT; k++) begin : g_lane
            irq_route_lane #(
                .SRC_W(SRC_W)
            ) lane_i (
                .clk   (clk),
                .rst_n (rst_n),
                .src   (src_irq),
                .route (route_q[k]),
                .enable(mask_q[k]),
                .irq   (cpu_irq[k])
            );
        end
    endgenerate

endmodule

// File: rtl/irq_route_matrix_chk.sv
// Module: assertion checker bound to the routing matrix top.
module irq_route_matrix_chk #(
    parameter int SRC_W   = 32,
    parameter int NUM_OUT = 6,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SRC_W-1:0]   src_irq,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic [SRC_W-1:0]   cfg_rdata,
    input logic [NUM_OUT-1:0] mask_q,
    input logic [NUM_OUT-1:0] cpu_irq
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_OUT + 1);

    // R1
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (cpu_irq == '0));

    // R6
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_irq & ~$past(mask_q)) == '0));

    // R7
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_irq == '0) |=> (cpu_irq == '0));

    // R4
    status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == STAT_A) |=> (cfg_rdata == $past(src_irq)));

    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr > STAT_A) |=> (cfg_rdata == '0));

    // R5
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq[0]) |-> ($past(src_irq) != '0));

endmodule

bind irq_route_matrix irq_route_matrix_chk #(
    .SRC_W  (SRC_W),
    .NUM_OUT(NUM_OUT),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_irq  (src_irq),
    .cfg_addr (cfg_addr),
    .cfg_rdata(cfg_rdata),
    .mask_q   (mask_q),
    .cpu_irq  (cpu_irq)
);

// File: tb/irq_route_matrix_tb_top.sv
// Directed bench for the interrupt routing matrix.
module irq_route_matrix_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_irq = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [5:0]  cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_route_matrix dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_irq  (src_irq),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .cpu_irq  (cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        @(negedge clk);
        d = cfg_rdata;
    endtask

    task automatic set_src(input logic [31:0] s);
        @(negedge clk);
        src_irq = s;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 outputs", {26'd0, cpu_irq}, 32'd0);
        for (int k = 0; k < 6; k++) begin
            rd(4'(k), d);
            check("R1 route", d, 32'd0);
        end
        rd(4'd6, d);
        check("R1 mask", d, 32'd0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        for (int k = 0; k < 6; k++) wr(4'(k), 32'hC0DE_0000 ^ (32'h0101_0101 << k));
        for (int k = 0; k < 6; k++) begin
            rd(4'(k), d);
            check("R2 readback", d, 32'hC0DE_0000 ^ (32'h0101_0101 << k));
        end
    endtask

    task automatic t_mask_reg();
        logic [31:0] d;
        wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd6, d);
        check("R3 mask width", d, 32'h0000_003F);
        wr(4'd6, 32'h0000_0015);
        rd(4'd6, d);
        check("R3 mask value", d, 32'h0000_0015);
    endtask

    task automatic t_status();
        logic [31:0] d;
        src_irq = 32'hA5A5_0001;
        rd(4'd7, d);
        check("R4 status", d, 32'hA5A5_0001);
        wr(4'd7, 32'h1234_5678);
        rd(4'd7, d);
        check("R4 status after write", d, 32'hA5A5_0001);
        src_irq = '0;
    endtask

    task automatic t_route();
        for (int k = 0; k < 6; k++) wr(4'(k), 32'd0);
        wr(4'd6, 32'h3F);
        wr(4'd0, 32'h0000_0008);
        wr(4'd1, 32'h0020_0000);
        set_src(32'h0000_0008);
        check("R5 source 3 to out 0", {26'd0, cpu_irq}, 32'h01);
        set_src(32'h0020_0000);
        check("R5 source 21 to out 1", {26'd0, cpu_irq}, 32'h02);
        set_src(32'hFFDF_FFF7);
        check("R10 unrouted sources", {26'd0, cpu_irq}, 32'h00);
        set_src(32'd0);
    endtask

    task automatic t_mask();
        wr(4'd6, 32'h3E);
        set_src(32'h0000_0008);
        check("R6 masked out 0", {26'd0, cpu_irq}, 32'h00);
        wr(4'd6, 32'h3F);
        @(negedge clk);
        check("R6 unmasked out 0", {26'd0, cpu_irq}, 32'h01);
        set_src(32'd0);
    endtask

    task automatic t_level();
        set_src(32'h0000_0008);
        repeat (4) @(negedge clk);
        check("R7 held high", {26'd0, cpu_irq}, 32'h01);
        src_irq = 32'd0;
        check("R7 still high before edge", {26'd0, cpu_irq}, 32'h01);
        @(negedge clk);
        check("R7 dropped one cycle later", {26'd0, cpu_irq}, 32'h00);
    endtask

    task automatic t_fanout();
        for (int k = 0; k < 6; k++) wr(4'(k), 32'h0000_0080);
        set_src(32'h0000_0080);
        check("R8 fan-out", {26'd0, cpu_irq}, 32'h3F);
        set_src(32'd0);
        check("R8 fan-out drop", {26'd0, cpu_irq}, 32'h00);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        for (int a = 8; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
        rd(4'd9, d);
        check("R9 unmapped read", d, 32'd0);
        rd(4'd15, d);
        check("R9 unmapped read top", d, 32'd0);
        for (int k = 0; k < 6; k++) begin
            rd(4'(k), d);
            check("R9 route unchanged", d, 32'h0000_0080);
        end
        rd(4'd6, d);
        check("R9 mask unchanged", d, 32'h3F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_mask_reg();
        t_status();
        t_route();
        t_mask();
        t_level();
        t_fanout();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule